// File: doc/BRIEF.md
# DMA Interrupt Coalescing Unit

This block batches the completion interrupts of one DMA channel. A frame counter starts from a programmable threshold and counts down once per completed frame; when the last frame of a batch completes, it emits a one-cycle completion-interrupt set pulse and starts the next batch from the threshold. The threshold is an 8-bit field, and a value of zero means a batch of 256 frames.

A separate delay timer catches a batch that never fills. Each completed frame restarts the timer from a programmable 8-bit delay, as long as that delay is nonzero. The timer counts down on cycles where a prescaled tick enable is high. When it steps from 1 to 0 it emits a one-cycle delay-interrupt set pulse and restarts the batch counter from the threshold, then waits at zero. A reload strobe, raised by the register block on every control write, also restarts the batch counter. The current batch count and the remaining timer count are brought out for status readback. The sticky flags and the interrupt mask live in the register block.

Top module: `dma_irq_coalescer`

## Requirements
- R1: After reset the batch count reads 1, the timer count reads 0, and neither set pulse is active.
- R2: A frame-complete pulse when the batch count is greater than 1 lowers the count by one on the next clock.
- R3: A frame-complete pulse when the batch count is 1 raises the completion set pulse on the next clock and reloads the count from the threshold.
- R4: A threshold of 0 loads a count of 0 (read as 0) and yields exactly one completion pulse per 256 frames.
- R5: A reload strobe loads the batch count from the threshold on the next clock. A frame-complete pulse in the same cycle is not counted and gives no completion pulse.
- R6: A frame-complete pulse with a nonzero delay loads the timer with the delay on the next clock, whatever the tick input does.
- R7: A frame-complete pulse with a delay of 0 leaves the timer's countdown unaffected.
- R8: The timer lowers its count by one only on cycles where the tick enable is high and the count is nonzero; at zero it stays at zero.
- R9: A tick that takes the timer from 1 to 0 raises the delay set pulse on the next clock. Unless a reload strobe or a frame-complete pulse wins in that cycle, it also reloads the batch count from the threshold.
- R10: Each set pulse is active for one clock per event; the two pulses are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done_i | input | 1 | One-cycle pulse per completed frame |
| thresh_i | input | 8 | Frames per completion interrupt (0 = 256) |
| delay_i | input | 8 | Timer restart value; 0 disables restart |
| reload_i | input | 1 | Control-write strobe; reloads the batch count |
| tick_en_i | input | 1 | Prescaled timer tick enable |
| ioc_set_o | output | 1 | Completion-interrupt set pulse |
| dly_set_o | output | 1 | Delay-interrupt set pulse |
| cnt_o | output | 8 | Current batch count |
| tmr_o | output | 8 | Remaining timer count |

## Verification
The hardest case to reach is timer expiry colliding with other events in the same cycle. Examples are an expiry tick that lands on a frame completion with zero delay, and a reload strobe that arrives during the expiry cycle. Directed phases line these up by counting ticks to the timer's last step. A long random phase then mixes frames, strobes, ticks and changing fields against a behavioural model, which is compared on every clock. The 256-frame batch is walked out in full so that the wrap of the zero threshold is seen to fire once.

// File: rtl/coal_pkg.sv
package coal_pkg;
  parameter int unsigned CNT_W      = 8;
  parameter int unsigned TMR_W      = 8;
  parameter int unsigned RB_W       = 8;
  parameter int unsigned RST_THRESH = 1;
endpackage

// File: rtl/coal_frame_counter.sv
module coal_frame_counter #(
  parameter int unsigned CNT_W  = coal_pkg::CNT_W,
  parameter int unsigned RST_VAL = coal_pkg::RST_THRESH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done_i,
  input  logic             reload_i,
  input  logic             expire_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ioc_set_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] RSTV = CNT_W'(RST_VAL);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ioc_q, ioc_d;
  logic             cnt_en;
  logic             last_frame;

  assign last_frame = frame_done_i && !reload_i && (cnt_q == ONE);

  always_comb begin
    cnt_en = reload_i || frame_done_i || expire_i;
    cnt_d  = cnt_q;
    if (reload_i)           cnt_d = thresh_i;
    else if (frame_done_i)  cnt_d = (cnt_q == ONE) ? thresh_i : cnt_q - ONE;
    else if (expire_i)      cnt_d = thresh_i;
    ioc_d = last_frame;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RSTV;
      ioc_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      ioc_q <= ioc_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign ioc_set_o = ioc_q;

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (cnt_q == $past(thresh_i)) && !ioc_q);
  p_ioc_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ioc_q |-> (cnt_q == $past(thresh_i)));
  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done_i && !reload_i && cnt_q != ONE) |=> (cnt_q == $past(cnt_q) - ONE));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_done_i && !reload_i && !expire_i) |=> $stable(cnt_q));
endmodule

// File: rtl/coal_delay_timer.sv
module coal_delay_timer #(
  parameter int unsigned TMR_W = coal_pkg::TMR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done_i,
  input  logic             tick_en_i,
  input  logic [TMR_W-1:0] delay_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             expire_o,
  output logic             dly_set_o
);
  localparam logic [TMR_W-1:0] ONE  = TMR_W'(1);
  localparam logic [TMR_W-1:0] ZERO = '0;

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             dly_q;
  logic             restart;
  logic             step;
  logic             tmr_en;

  assign restart  = frame_done_i && (delay_i != ZERO);
  assign step     = tick_en_i && (tmr_q != ZERO);
  assign expire_o = step && !restart && (tmr_q == ONE);

  always_comb begin
    tmr_en = restart || step;
    tmr_d  = tmr_q;
    if (restart)   tmr_d = delay_i;
    else if (step) tmr_d = tmr_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= ZERO;
      dly_q <= 1'b0;
    end else begin
      if (tmr_en) tmr_q <= tmr_d;
      dly_q <= expire_o;
    end
  end

  assign tmr_o     = tmr_q;
  assign dly_set_o = dly_q;

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tmr_q == $past(delay_i)));
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((tmr_q == ZERO) && !restart) |=> (tmr_q == ZERO));
  p_notick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en_i && !restart) |=> $stable(tmr_q));
  p_expire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dly_q |-> (tmr_q == ZERO));
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dly_q |=> !dly_q);
endmodule

// File: rtl/dma_irq_coalescer.sv
module dma_irq_coalescer #(
  parameter int unsigned CNT_W = coal_pkg::CNT_W,
  parameter int unsigned TMR_W = coal_pkg::TMR_W,
  parameter int unsigned RB_W  = coal_pkg::RB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [TMR_W-1:0] delay_i,
  input  logic             reload_i,
  input  logic             tick_en_i,
  output logic             ioc_set_o,
  output logic             dly_set_o,
  output logic [RB_W-1:0]  cnt_o,
  output logic [RB_W-1:0]  tmr_o
);
  logic [CNT_W-1:0] cnt_w;
  logic [TMR_W-1:0] tmr_w;
  logic             expire_w;

  coal_delay_timer #(.TMR_W(TMR_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_done_i (frame_done_i),
    .tick_en_i    (tick_en_i),
    .delay_i      (delay_i),
    .tmr_o        (tmr_w),
    .expire_o     (expire_w),
    .dly_set_o    (dly_set_o)
  );

  coal_frame_counter #(.CNT_W(CNT_W)) u_count (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_done_i (frame_done_i),
    .reload_i     (reload_i),
    .expire_i     (expire_w),
    .thresh_i     (thresh_i),
    .cnt_o        (cnt_w),
    .ioc_set_o    (ioc_set_o)
  );

  assign cnt_o = cnt_w[RB_W-1:0];
  assign tmr_o = tmr_w[RB_W-1:0];

  p_ioc_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ioc_set_o |=> !ioc_set_o || $past(frame_done_i));
  p_expire_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && !reload_i && !frame_done_i) |=> (cnt_o == $past(thresh_i)));
endmodule

// File: tb/dma_irq_coalescer_tb_top.sv
module dma_irq_coalescer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_done_i = 1'b0, reload_i = 1'b0, tick_en_i = 1'b0;
  logic [7:0] thresh_i = 8'd0, delay_i = 8'd0;
  logic       ioc_set_o, dly_set_o;
  logic [7:0] cnt_o, tmr_o;

  always #10 clk = ~clk;

  dma_irq_coalescer dut_i (
    .clk(clk), .rst_n(rst_n), .frame_done_i(frame_done_i), .thresh_i(thresh_i),
    .delay_i(delay_i), .reload_i(reload_i), .tick_en_i(tick_en_i),
    .ioc_set_o(ioc_set_o), .dly_set_o(dly_set_o), .cnt_o(cnt_o), .tmr_o(tmr_o));

  int checks = 0, errors = 0, cycles = 0, ioc_seen = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference: batch count kept as 1..256
  int m_cnt = 1, m_tmr = 0;
  bit m_ioc = 0, m_dly = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int full(int t);
    return (t == 0) ? 256 : t;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 1; m_tmr = 0; m_ioc = 0; m_dly = 0;
    end else begin
      bit ex, rs;
      rs = frame_done_i && (delay_i != 0);
      ex = tick_en_i && (m_tmr == 1) && !rs;
      m_ioc = frame_done_i && !reload_i && (m_cnt == 1);
      if (reload_i) m_cnt = full(thresh_i);
      else if (frame_done_i) m_cnt = (m_cnt == 1) ? full(thresh_i) : m_cnt - 1;
      else if (ex) m_cnt = full(thresh_i);
      if (rs) m_tmr = delay_i;
      else if (tick_en_i && m_tmr > 0) m_tmr = m_tmr - 1;
      m_dly = ex;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cnt_o == 8'(m_cnt % 256), cur_req, "cnt_o", cnt_o, m_cnt % 256);
      chk(tmr_o == 8'(m_tmr), cur_req, "tmr_o", tmr_o, m_tmr);
      chk(ioc_set_o == m_ioc, cur_req, "ioc_set_o", ioc_set_o, m_ioc);
      chk(dly_set_o == m_dly, cur_req, "dly_set_o", dly_set_o, m_dly);
      if (ioc_set_o) ioc_seen++;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic cyc(bit f, bit w, bit t);
    @(negedge clk);
    frame_done_i = f; reload_i = w; tick_en_i = t;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    cur_req = "R1";
    chk(cnt_o == 8'd1 && tmr_o == 8'd0 && !ioc_set_o && !dly_set_o, "R1", "reset state",
        {cnt_o, tmr_o}, 16'h0100);
    // R2/R3: batch of 3
    cur_req = "R2"; thresh_i = 8'd3; delay_i = 8'd0;
    cyc(0,1,0); cyc(1,0,0); cyc(1,0,0);
    cur_req = "R3"; cyc(1,0,0); cyc(1,0,0); cyc(0,0,0); cyc(1,0,0); cyc(1,0,0); cyc(0,0,0);
    // R10: consecutive batches of 1
    cur_req = "R10"; thresh_i = 8'd1; cyc(0,1,0); cyc(1,0,0); cyc(1,0,0); cyc(0,0,0); cyc(0,0,0);
    // R5: reload with frame in same cycle
    cur_req = "R5"; thresh_i = 8'd1; cyc(1,1,0); cyc(0,0,0);
    thresh_i = 8'd5; cyc(1,1,0); cyc(0,0,0);
    // R4: threshold 0
    cur_req = "R4"; thresh_i = 8'd0; cyc(0,1,0); cyc(0,0,0);
    #1 chk(cnt_o == 8'd0, "R4", "zero threshold load", cnt_o, 0);
    ioc_seen = 0;
    for (int i = 0; i < 255; i++) cyc(1,0,0);
    cyc(0,0,0); cyc(0,0,0);
    #1 chk(ioc_seen == 0, "R4", "no pulse after 255 frames", ioc_seen, 0);
    cyc(1,0,0); cyc(0,0,0); cyc(0,0,0);
    #1 chk(ioc_seen == 1, "R4", "one pulse after 256 frames", ioc_seen, 1);
    // R6/R8/R9: timer
    cur_req = "R6"; thresh_i = 8'd4; delay_i = 8'd3; cyc(0,1,0); cyc(1,0,1);
    cur_req = "R8"; cyc(0,0,0); cyc(0,0,1); cyc(0,0,0); cyc(0,0,1);
    cur_req = "R9"; cyc(0,0,1); cyc(0,0,0); cyc(0,0,1); cyc(0,0,1); cyc(0,0,0);
    #1 chk(tmr_o == 8'd0 && cnt_o == 8'd4, "R9", "expired timer and reloaded count",
           {tmr_o, cnt_o}, 16'h0004);
    // R7: frame with zero delay during countdown, expiry collides with frame
    cur_req = "R7"; delay_i = 8'd2; cyc(1,0,0); delay_i = 8'd0;
    cyc(1,0,1); cyc(1,0,1); cyc(0,0,0);
    // R9: expiry colliding with reload strobe
    cur_req = "R9"; delay_i = 8'd1; cyc(1,0,0); thresh_i = 8'd7; cyc(0,1,1); cyc(0,0,0);
    // R6: restart wins over expiring tick
    cur_req = "R6"; delay_i = 8'd1; cyc(1,0,0); delay_i = 8'd9; cyc(1,0,1); cyc(0,0,0);
    // mixed random traffic
    cur_req = "R10";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      frame_done_i = ($urandom % 3) == 0;
      reload_i     = ($urandom % 23) == 0;
      tick_en_i    = ($urandom % 2) == 0;
      if (($urandom % 50) == 0) thresh_i = 8'($urandom % 6);
      if (($urandom % 40) == 0) delay_i  = 8'($urandom % 8);
    end
    cyc(0,0,0); cyc(0,0,0);
    finish_run();
  end
endmodule